// File: doc/BRIEF.md
# Video Processor Host Port

This block is the processor-facing side of a tile-based video display processor. It gives the host three one-cycle strobes: a data-port read, a data-port write and a control-port write. It also accepts a status-port read strobe, which returns a status byte supplied by the rendering side. Behind the ports sit a 14-bit video RAM address counter, a one-byte buffer and eight 8-bit internal registers. The block drives a synchronous 16K-byte video RAM port.

The control port takes bytes in pairs. The first byte is held in a latch and also goes into the low half of the address at once. The second byte always supplies the upper six address bits. Its two top bits then choose what else happens. Bit 7 copies the held first byte into the register named by bits 2:0. If both top bits are clear, a prefetch reads the byte at the new address into the buffer and steps the address. Setting either top bit suppresses that prefetch. There is no separate read mode or write mode. Data reads and data writes work the same way whatever control bits set the address, and they share the one buffer.

A data read hands the host the byte already in the buffer. The buffer is then refilled from the current address and the address steps. A data write puts the byte in the buffer, stores it to the current address and steps the address. All memory traffic starts in the cycle after the strobe that causes it.

Top module: `vdp_host_port`

## Requirements
- R1: After reset the address is 0x0000, all eight registers are 0x00, the buffer is 0x00 and the control port expects a first byte.
- R2: A control-port write while a first byte is expected loads the byte into address bits 7:0 at once. Any status read, data read or data write makes the next control byte a first byte again.
- R3: The second control byte always loads its bits 5:0 into address bits 13:8, whatever its bits 7:6 hold.
- R4: When bit 7 of the second control byte is set, the held first byte is written to the register indexed by bits 2:0 of the second byte. Register n appears on `regs_flat[8n+7:8n]`.
- R5: When bit 7 or bit 6 of the second control byte is set, no memory read occurs, the buffer is unchanged and the address keeps the loaded value.
- R6: When bits 7:6 of the second control byte are both 0, the byte at the loaded address is fetched into the buffer and the address then steps by one.
- R7: A data read returns the buffer contents on `host_dout`. It then refills the buffer from the current address and steps the address by one.
- R8: A data write places the byte in the buffer, stores it to the current address and steps the address by one, regardless of which control bits set that address.
- R9: Address stepping wraps from 0x3FFF to 0x0000.
- R10: A data read that directly follows a data write returns the byte just written.
- R11: A status read returns the `stat_in` byte on `host_dout`.
- R12: A data write raises `vram_we` in the cycle after the strobe, with the written byte on `vram_wdata` and the pre-step address on `vram_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control-port write strobe, one cycle |
| data_wr | input | 1 | Data-port write strobe, one cycle |
| data_rd | input | 1 | Data-port read strobe, one cycle |
| stat_rd | input | 1 | Status-port read strobe, one cycle |
| host_din | input | 8 | Byte from the host for control or data writes |
| stat_in | input | 8 | Status byte supplied by the rendering side |
| host_dout | output | 8 | Byte returned by the last data or status read |
| vram_addr | output | 14 | Video RAM address, equal to the address counter |
| vram_we | output | 1 | Video RAM write enable |
| vram_re | output | 1 | Video RAM read enable, data due the following cycle |
| vram_wdata | output | 8 | Video RAM write data |
| vram_rdata | input | 8 | Video RAM read data, one cycle after `vram_re` |
| regs_flat | output | 64 | Eight internal registers, register n at bits 8n+7:8n |

## Verification
The assertions rely on the host never raising two strobes in the same cycle. They also rely on the host leaving at least two idle cycles after each strobe, so that a pending memory access and its buffer refill finish before the next strobe can move the address or the buffer. Each bench task raises exactly one strobe for one cycle and then waits three cycles before returning. This keeps every scenario inside that spacing, and every check samples outputs after the refill has settled.

// File: rtl/vdp_pkg.sv
package vdp_pkg;

    localparam int ADDR_W    = 14;
    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int HI_BITS_W = ADDR_W - BYTE_W;

    typedef logic [ADDR_W-1:0]    vaddr_t;
    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic {
        SEL_FIRST  = 1'b0,
        SEL_SECOND = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic                 load_lo;
        logic                 load_hi;
        byte_t                lo_val;
        logic [HI_BITS_W-1:0] hi_bits;
        logic [1:0]           hi_ctl;
        logic                 reg_we;
        reg_idx_t             reg_idx;
        byte_t                reg_data;
        logic                 fetch;
    } ctrl_cmd_t;

    function automatic vaddr_t vaddr_step(input vaddr_t a);
        return a + vaddr_t'(1);
    endfunction

    function automatic logic ctl_allows_fetch(input logic [1:0] ctl);
        return ctl == 2'b00;
    endfunction

endpackage

// File: rtl/vdp_ctrl_seq.sv
module vdp_ctrl_seq
    import vdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic       stat_rd,
    input  logic       data_access,
    input  byte_t      din,
    output ctrl_cmd_t  cmd
);

    byte_sel_e sel_q;
    byte_t     held_q;

    always_comb begin
        cmd          = '0;
        cmd.load_lo  = ctrl_wr && (sel_q == SEL_FIRST);
        cmd.load_hi  = ctrl_wr && (sel_q == SEL_SECOND);
        cmd.lo_val   = din;
        cmd.hi_bits  = din[HI_BITS_W-1:0];
        cmd.hi_ctl   = din[7:6];
        cmd.reg_we   = cmd.load_hi && din[7];
        cmd.reg_idx  = din[REG_IDX_W-1:0];
        cmd.reg_data = held_q;
        cmd.fetch    = cmd.load_hi && ctl_allows_fetch(din[7:6]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= SEL_FIRST;
            held_q <= '0;
        end else if (ctrl_wr) begin
            if (sel_q == SEL_FIRST) begin
                held_q <= din;
                sel_q  <= SEL_SECOND;
            end else begin
                sel_q  <= SEL_FIRST;
            end
        end else if (stat_rd || data_access) begin
            sel_q <= SEL_FIRST;
        end
    end

    // R2
    sel_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd || data_access) && !ctrl_wr |=> (sel_q == SEL_FIRST));

    // R2
    sel_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.load_hi |=> (sel_q == SEL_FIRST));

endmodule

// File: rtl/vdp_regfile.sv
module vdp_regfile
    import vdp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  reg_idx_t                 idx,
    input  byte_t                    wdata,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    byte_t regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (we && (idx == reg_idx_t'(g))) begin
                regs_q[g] <= wdata;
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    // R4
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/vdp_datapath.sv
module vdp_datapath
    import vdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctrl_cmd_t cmd,
    input  logic      data_rd,
    input  logic      data_wr,
    input  logic      stat_rd,
    input  byte_t     din,
    input  byte_t     stat_in,
    input  byte_t     vram_rdata,
    output vaddr_t    vram_addr,
    output logic      vram_we,
    output logic      vram_re,
    output byte_t     vram_wdata,
    output byte_t     host_dout
);

    vaddr_t addr_q;
    byte_t  buf_q;
    byte_t  dout_q;
    logic   wr_pend_q;
    logic   rd_pend_q;
    logic   fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            buf_q     <= '0;
            dout_q    <= '0;
            wr_pend_q <= 1'b0;
            rd_pend_q <= 1'b0;
            fill_q    <= 1'b0;
        end else begin
            wr_pend_q <= data_wr;
            rd_pend_q <= data_rd || cmd.fetch;
            fill_q    <= rd_pend_q;

            if (wr_pend_q || rd_pend_q) begin
                addr_q <= vaddr_step(addr_q);
            end
            if (cmd.load_lo) begin
                addr_q[BYTE_W-1:0] <= cmd.lo_val;
            end
            if (cmd.load_hi) begin
                addr_q[ADDR_W-1:BYTE_W] <= cmd.hi_bits;
            end

            if (data_wr) begin
                buf_q <= din;
            end else if (fill_q) begin
                buf_q <= vram_rdata;
            end

            if (data_rd) begin
                dout_q <= buf_q;
            end else if (stat_rd) begin
                dout_q <= stat_in;
            end
        end
    end

    assign vram_addr  = addr_q;
    assign vram_we    = wr_pend_q;
    assign vram_re    = rd_pend_q;
    assign vram_wdata = buf_q;
    assign host_dout  = dout_q;

    // R12
    write_issue_chk: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (vram_we && !vram_re && vram_wdata == $past(din)));

    // R7
    read_return_chk: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> (host_dout == $past(buf_q)));

    // R5
    no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.load_hi && (cmd.hi_ctl != 2'b00) && !data_rd |=> !vram_re);

    // R3
    hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.load_hi |=> (vram_addr[ADDR_W-1:BYTE_W] == $past(cmd.hi_bits)));

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vram_we || vram_re) && !cmd.load_lo && !cmd.load_hi
        |=> (vram_addr == vaddr_t'($past(vram_addr) + 1'b1)));

endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic        data_wr,
    input  logic        data_rd,
    input  logic        stat_rd,
    input  logic [7:0]  host_din,
    input  logic [7:0]  stat_in,
    output logic [7:0]  host_dout,
    output logic [13:0] vram_addr,
    output logic        vram_we,
    output logic        vram_re,
    output logic [7:0]  vram_wdata,
    input  logic [7:0]  vram_rdata,
    output logic [63:0] regs_flat
);

    ctrl_cmd_t cmd;

    vdp_ctrl_seq u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .stat_rd     (stat_rd),
        .data_access (data_rd || data_wr),
        .din         (host_din),
        .cmd         (cmd)
    );

    vdp_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cmd.reg_we),
        .idx       (cmd.reg_idx),
        .wdata     (cmd.reg_data),
        .regs_flat (regs_flat)
    );

    vdp_datapath u_data (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .stat_rd    (stat_rd),
        .din        (host_din),
        .stat_in    (stat_in),
        .vram_rdata (vram_rdata),
        .vram_addr  (vram_addr),
        .vram_we    (vram_we),
        .vram_re    (vram_re),
        .vram_wdata (vram_wdata),
        .host_dout  (host_dout)
    );

endmodule

// File: tb/test_vdp_host_port.sv
`timescale 1ns/1ps
module test_vdp_host_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  stat_in = 8'hA0;
    logic [7:0]  host_dout;
    logic [13:0] vram_addr;
    logic        vram_we, vram_re;
    logic [7:0]  vram_wdata;
    logic [7:0]  vram_rdata;
    logic [63:0] regs_flat;

    logic [7:0]  mem [1024];
    logic [63:0] exp_regs = '0;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    vdp_host_port i_vdp_host_port (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .data_rd(data_rd), .stat_rd(stat_rd), .host_din(host_din),
        .stat_in(stat_in), .host_dout(host_dout), .vram_addr(vram_addr),
        .vram_we(vram_we), .vram_re(vram_re), .vram_wdata(vram_wdata),
        .vram_rdata(vram_rdata), .regs_flat(regs_flat)
    );

    // Memory model: 1K bytes aliased over the 16K space
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
            vram_rdata <= 8'h00;
        end else begin
            if (vram_we) mem[vram_addr[9:0]] <= vram_wdata;
            if (vram_re) vram_rdata <= mem[vram_addr[9:0]];
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctrl_byte(input logic [7:0] b);
        @(negedge clk); host_din = b; ctrl_wr = 1'b1;
        @(negedge clk); ctrl_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_addr(input logic [13:0] a, input logic [1:0] ctl);
        ctrl_byte(a[7:0]);
        ctrl_byte({ctl, a[13:8]});
    endtask

    task automatic data_write(input logic [7:0] b);
        logic [13:0] a;
        a = vram_addr;
        @(negedge clk); host_din = b; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
        check("R12 vram_we", {63'd0, vram_we}, 64'd1);
        check("R12 vram_addr", {50'd0, vram_addr}, {50'd0, a});
        check("R12 vram_wdata", {56'd0, vram_wdata}, {56'd0, b});
        repeat (2) @(negedge clk);
    endtask

    task automatic data_read(output logic [7:0] r);
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        repeat (2) @(negedge clk);
        r = host_dout;
    endtask

    task automatic status_read(output logic [7:0] r);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        repeat (2) @(negedge clk);
        r = host_dout;
    endtask

    task automatic t_reset;
        logic [7:0] r;
        check("R1 address", {50'd0, vram_addr}, 64'd0);
        check("R1 registers", regs_flat, 64'd0);
        data_read(r);
        check("R1 buffer", {56'd0, r}, 64'd0);
        check("R7 step after read", {50'd0, vram_addr}, 64'd1);
    endtask

    task automatic t_write_fill;
        set_addr(14'h0100, 2'b01);
        check("R5 bit6 no prefetch", {50'd0, vram_addr}, 64'h100);
        data_write(8'h11); data_write(8'h22); data_write(8'h33);
        check("R8 addr step", {50'd0, vram_addr}, 64'h103);
        check("R8 stored", {40'd0, mem[10'h100], mem[10'h101], mem[10'h102]}, 64'h112233);
    endtask

    task automatic t_read_seq;
        logic [7:0] r;
        set_addr(14'h0100, 2'b00);
        check("R6 prefetch step", {50'd0, vram_addr}, 64'h101);
        data_read(r);
        check("R7 first read", {56'd0, r}, 64'h11);
        check("R7 addr", {50'd0, vram_addr}, 64'h102);
        data_read(r);
        check("R7 second read", {56'd0, r}, 64'h22);
    endtask

    task automatic t_write_then_read;
        logic [7:0] r;
        set_addr(14'h0200, 2'b01);
        data_write(8'h5A);
        data_read(r);
        check("R10 read after write", {56'd0, r}, 64'h5A);
        check("R10 addr", {50'd0, vram_addr}, 64'h202);
    endtask

    task automatic t_bit6_then_read;
        logic [7:0] r;
        set_addr(14'h0300, 2'b01);
        data_write(8'h77);
        set_addr(14'h0100, 2'b01);
        check("R5 addr held", {50'd0, vram_addr}, 64'h100);
        data_read(r);
        check("R5 stale buffer", {56'd0, r}, 64'h77);
        data_read(r);
        check("R7 refill", {56'd0, r}, 64'h11);
    endtask

    task automatic t_read_addr_then_write;
        set_addr(14'h0100, 2'b00);
        data_write(8'h99);
        check("R8 write after prefetch", {48'd0, mem[10'h100], mem[10'h101]}, 64'h1199);
        check("R8 addr", {50'd0, vram_addr}, 64'h102);
    endtask

    task automatic t_registers;
        ctrl_byte(8'hA5); ctrl_byte(8'h83);
        exp_regs[3*8 +: 8] = 8'hA5;
        check("R4 reg3", regs_flat, exp_regs);
        check("R3 R5 addr after reg write", {50'd0, vram_addr}, 64'h03A5);
        ctrl_byte(8'h3C); ctrl_byte(8'h87);
        exp_regs[7*8 +: 8] = 8'h3C;
        check("R4 reg7", regs_flat, exp_regs);
        set_addr(14'h3A21, 2'b01);
        check("R3 hi bits", {50'd0, vram_addr}, 64'h3A21);
        check("R4 no reg write", regs_flat, exp_regs);
    endtask

    task automatic t_byte_select;
        logic [7:0] r;
        ctrl_byte(8'h55);
        check("R2 first byte low addr", {56'd0, vram_addr[7:0]}, 64'h55);
        status_read(r);
        check("R11 status", {56'd0, r}, 64'hA0);
        ctrl_byte(8'h34);
        check("R2 status resets select", {56'd0, vram_addr[7:0]}, 64'h34);
        ctrl_byte(8'h40);
        check("R2 pair after status", {50'd0, vram_addr}, 64'h0034);
        check("R2 regs untouched", regs_flat, exp_regs);
        ctrl_byte(8'h66);
        data_read(r);
        ctrl_byte(8'h10); ctrl_byte(8'h45);
        check("R2 data read resets select", {50'd0, vram_addr}, 64'h0510);
    endtask

    task automatic t_wrap;
        set_addr(14'h3FFF, 2'b01);
        data_write(8'hC3);
        check("R9 wrap", {50'd0, vram_addr}, 64'h0);
        data_write(8'hD4);
        check("R9 stored", {48'd0, mem[10'h3FF], mem[10'h000]}, 64'hC3D4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_write_fill;
        t_read_seq;
        t_write_then_read;
        t_bit6_then_read;
        t_read_addr_then_write;
        t_registers;
        t_byte_select;
        t_wrap;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule